// File: doc/BRIEF.md
# Configurable Serial Peripheral Port (Master/Slave)

This block is a byte-wide synchronous serial port that works either as the clock-generating master or as a slave that follows an external clock. Software controls it through three bus-addressed registers: a control register, a status register and a data register. The control register enables the port, picks its role, sets the clock idle level and the clock phase, and gives a two-bit rate code. In master mode that code divides the bus clock to make the serial clock. It also holds the enable for the interrupt request.

In master mode, a write to the data register starts a transfer. The port drives the serial clock and its output line, and it samples its input line, most significant bit first. In slave mode, the external clock and an active-low select are synchronised into the bus clock domain. With phase 0, the falling edge of select starts the frame and puts the first bit on the slave output at once. With phase 1, the frame starts at the first clock edge. After the eighth bit, the received byte moves into a read buffer and a completion flag sets. The flag drives the interrupt request when that request is enabled.

Top module: `spi_port`

## Requirements
- R1: The control register is at address 0. Its bits are: bit 7 interrupt enable, bit 6 unused (reads 0), bit 5 port enable, bit 4 master select, bit 3 clock polarity, bit 2 clock phase, bits 1:0 rate code. Reset clears bits 7 and 5..2. Reset leaves the rate code unchanged.
- R2: Address 1 is status, with the completion flag in bit 7 and all other bits reading 0. Address 2 is data: a write loads the transmit byte, and a read returns the last received byte.
- R3: In master mode, rate codes 0, 1, 2 and 3 give a serial-clock half period of 1, 2, 8 and 16 bus clocks (division by 2, 4, 16 and 32).
- R4: The master's serial clock output rests at the clock-polarity value whenever no transfer is running, before and after a transfer.
- R5: In master mode with phase 0, the most significant bit is on the data output before the first clock edge. The input is sampled on each leading edge and the next bit is launched on each trailing edge. Eight bits are sent, MSB first.
- R6: In master mode with phase 1, each bit is launched on a leading edge and the input is sampled on the trailing edge, MSB first.
- R7: In slave mode with phase 0, select going low starts the frame and presents the transmit byte's MSB on the slave output. The slave samples on leading edges and launches on trailing edges.
- R8: In slave mode with phase 1, the slave launches on leading edges and samples on trailing edges. In slave mode the rate code has no effect on transfers.
- R9: After the eighth bit, the completion flag sets and the received byte becomes readable at address 2.
- R10: A status read made while the flag is set, followed by a data-register access, clears the flag. A data access without that earlier status read leaves the flag set.
- R11: The interrupt request is high exactly when the completion flag and the interrupt enable are both set.
- R12: The clock and data output enables of master mode are high only when the port is enabled in master mode. The slave output enable is high only when the port is enabled in slave mode with select low.
- R13: With the port disabled, a data write starts no transfer: the serial clock does not toggle and the flag stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | Register access strobe |
| we_i | input | 1 | Write (1) or read (0) |
| addr_i | input | 2 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data (combinational) |
| irq_o | output | 1 | Interrupt request |
| sck_i | input | 1 | Serial clock in (slave) |
| sck_o | output | 1 | Serial clock out (master) |
| sck_oe_o | output | 1 | Serial clock output enable |
| ss_ni | input | 1 | Active-low slave select |
| mosi_i | input | 1 | Master-out line in (slave) |
| mosi_o | output | 1 | Master-out line out (master) |
| mosi_oe_o | output | 1 | Master-out output enable |
| miso_i | input | 1 | Master-in line in (master) |
| miso_o | output | 1 | Master-in line out (slave) |
| miso_oe_o | output | 1 | Master-in output enable |

## Verification
A wrong edge counter or a wrong divider count in the master is visible on the serial clock pin within one half period. It shows as a gap between toggles that does not match the rate, as the wrong number of toggles, or as the clock resting at the wrong level. If the shift register or the launch/sample phase is wrong, the bench's model peer captures a different byte on the data line by the end of the frame. The read-back at address 2 also shows a different byte right after the flag sets. A fault in the flag/arm logic shows on the next status read or at the interrupt pin within one bus access.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  typedef struct packed {
    logic       irq_en;
    logic       enable;
    logic       master;
    logic       cpol;
    logic       cpha;
    logic [1:0] rate;
  } ctrl_t;

  // half period of the master clock in bus cycles
  function automatic int unsigned half_cycles(input logic [1:0] code);
    case (code)
      2'd0:    return 1;
      2'd1:    return 2;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

endpackage

// File: rtl/spi_sync.sv
module spi_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] stage_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) stage_q[i] <= RST_VAL;
        else if (i == 0) stage_q[i] <= d_i;
        else stage_q[i] <= stage_q[(i > 0) ? i - 1 : 0];
      end
    end
  endgenerate

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/spi_regs.sv
module spi_regs
  import spi_port_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  input  logic              done_i,
  input  logic [DATA_W-1:0] rx_i,
  output ctrl_t             ctrl_o,
  output logic              flag_o,
  output logic              data_wr_o,
  output logic [DATA_W-1:0] tx_buf_o
);
  logic              irq_en_q, enable_q, master_q, cpol_q, cpha_q;
  logic [1:0]        rate_q;
  logic              flag_q, armed_q;
  logic [DATA_W-1:0] rx_buf_q, tx_buf_q;
  logic              wr_ctrl, rd_stat, acc_data, clr_flag;

  assign wr_ctrl   = sel_i & we_i & (addr_i == ADDR_CTRL);
  assign rd_stat   = sel_i & ~we_i & (addr_i == ADDR_STAT);
  assign acc_data  = sel_i & (addr_i == ADDR_DATA);
  assign data_wr_o = acc_data & we_i;
  assign clr_flag  = acc_data & armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
      enable_q <= 1'b0;
      master_q <= 1'b0;
      cpol_q   <= 1'b0;
      cpha_q   <= 1'b0;
    end else if (wr_ctrl) begin
      irq_en_q <= wdata_i[7];
      enable_q <= wdata_i[5];
      master_q <= wdata_i[4];
      cpol_q   <= wdata_i[3];
      cpha_q   <= wdata_i[2];
    end
  end

  // rate code deliberately kept through reset
  always_ff @(posedge clk_i) begin
    if (wr_ctrl) rate_q <= wdata_i[1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q   <= 1'b0;
      armed_q  <= 1'b0;
      rx_buf_q <= '0;
      tx_buf_q <= '0;
    end else begin
      if (done_i) flag_q <= 1'b1;
      else if (clr_flag) flag_q <= 1'b0;
      if (done_i || clr_flag) armed_q <= 1'b0;
      else if (rd_stat && flag_q) armed_q <= 1'b1;
      if (done_i) rx_buf_q <= rx_i;
      if (data_wr_o) tx_buf_q <= wdata_i;
    end
  end

  always_comb begin
    case (addr_i)
      ADDR_CTRL: rdata_o = DATA_W'({irq_en_q, 1'b0, enable_q, master_q, cpol_q, cpha_q, rate_q});
      ADDR_STAT: rdata_o = {flag_q, {(DATA_W-1){1'b0}}};
      ADDR_DATA: rdata_o = rx_buf_q;
      default:   rdata_o = '0;
    endcase
  end

  assign ctrl_o   = '{irq_en: irq_en_q, enable: enable_q, master: master_q,
                      cpol: cpol_q, cpha: cpha_q, rate: rate_q};
  assign flag_o   = flag_q;
  assign tx_buf_o = tx_buf_q;
endmodule

// File: rtl/spi_rate_div.sv
module spi_rate_div
  import spi_port_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       run_i,
  input  logic [1:0] rate_i,
  output logic       tick_o
);
  logic [CNT_W-1:0] cnt_q, lim;

  assign lim    = CNT_W'(half_cycles(rate_i) - 1);
  assign tick_o = run_i && (cnt_q == lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/spi_master_eng.sv
module spi_master_eng #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpha_i,
  input  logic              start_i,
  input  logic [DATA_W-1:0] tx_i,
  input  logic              tick_i,
  input  logic              miso_i,
  output logic              busy_o,
  output logic              lvl_o,
  output logic              mosi_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int EDGES = 2 * DATA_W;
  localparam int EW    = $clog2(EDGES);

  logic              busy_q, lvl_q, out_q;
  logic [EW-1:0]     edge_q;
  logic [DATA_W-1:0] tx_q, rx_q, rx_next;
  logic              lead, last, step, sample, launch;

  assign lead    = ~edge_q[0];
  assign last    = edge_q == EW'(EDGES - 1);
  assign step    = busy_q & tick_i;
  assign sample  = step & (lead ^ cpha_i);
  assign launch  = step & ~(lead ^ cpha_i) & ~last;
  assign rx_next = {rx_q[DATA_W-2:0], miso_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      out_q  <= 1'b0;
      edge_q <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else if (!en_i) begin
      busy_q <= 1'b0;
      lvl_q  <= 1'b0;
      edge_q <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      lvl_q  <= 1'b0;
      edge_q <= '0;
      if (!cpha_i) begin
        out_q <= tx_i[DATA_W-1];
        tx_q  <= {tx_i[DATA_W-2:0], 1'b0};
      end else begin
        tx_q  <= tx_i;
      end
    end else if (step) begin
      lvl_q  <= ~lvl_q;
      edge_q <= edge_q + 1'b1;
      if (sample) rx_q <= rx_next;
      if (launch) begin
        out_q <= tx_q[DATA_W-1];
        tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
      end
      if (last) busy_q <= 1'b0;
    end
  end

  assign busy_o = busy_q;
  assign lvl_o  = lvl_q;
  assign mosi_o = out_q;
  assign done_o = step & last;
  assign rx_o   = sample ? rx_next : rx_q;
endmodule

// File: rtl/spi_slave_eng.sv
module spi_slave_eng #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              cpol_i,
  input  logic              cpha_i,
  input  logic              sck_i,
  input  logic              ss_ni,
  input  logic              mosi_i,
  input  logic [DATA_W-1:0] tx_i,
  output logic              miso_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rx_o
);
  localparam int BW = $clog2(DATA_W);

  logic              sck_s, ss_s, mosi_s;
  logic              lvl, lvl_q, ss_q;
  logic              active, lead, trail, ss_fall, sample, launch, last;
  logic [BW-1:0]     cnt_q;
  logic [DATA_W-1:0] tx_q, rx_q, rx_next;
  logic              out_q;

  spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sck (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sck_i), .q_o(sck_s));
  spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_ss (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(ss_ni), .q_o(ss_s));
  spi_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_mosi (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(mosi_i), .q_o(mosi_s));

  assign lvl     = sck_s ^ cpol_i;
  assign active  = en_i & ~ss_s;
  assign lead    = active & lvl & ~lvl_q;
  assign trail   = active & ~lvl & lvl_q;
  assign ss_fall = en_i & ss_q & ~ss_s;
  assign sample  = cpha_i ? trail : lead;
  assign launch  = cpha_i ? lead : trail;
  assign last    = cnt_q == BW'(DATA_W - 1);
  assign rx_next = {rx_q[DATA_W-2:0], mosi_s};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
      ss_q  <= 1'b1;
      cnt_q <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
      out_q <= 1'b0;
    end else begin
      lvl_q <= lvl;
      ss_q  <= ss_s;
      if (!active) begin
        cnt_q <= '0;
      end else if (sample) begin
        rx_q  <= rx_next;
        cnt_q <= last ? '0 : cnt_q + 1'b1;
      end
      // phase 0 loads on select fall, phase 1 on the first leading edge
      if (!cpha_i && ss_fall) begin
        out_q <= tx_i[DATA_W-1];
        tx_q  <= {tx_i[DATA_W-2:0], 1'b0};
      end else if (launch && cpha_i && cnt_q == '0) begin
        out_q <= tx_i[DATA_W-1];
        tx_q  <= {tx_i[DATA_W-2:0], 1'b0};
      end else if (launch) begin
        out_q <= tx_q[DATA_W-1];
        tx_q  <= {tx_q[DATA_W-2:0], 1'b0};
      end
    end
  end

  assign miso_o = out_q;
  assign done_o = sample & last;
  assign rx_o   = rx_next;
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter int DIV_CNT_W   = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe_o,
  input  logic              ss_ni,
  input  logic              mosi_i,
  output logic              mosi_o,
  output logic              mosi_oe_o,
  input  logic              miso_i,
  output logic              miso_o,
  output logic              miso_oe_o
);
  ctrl_t             ctrl_q;
  logic              flag, data_wr, done;
  logic [DATA_W-1:0] tx_buf, rx_byte;
  logic              m_en, s_en, tick;
  logic              m_busy, m_lvl, m_done, s_done;
  logic [DATA_W-1:0] m_rx, s_rx;

  assign m_en = ctrl_q.enable & ctrl_q.master;
  assign s_en = ctrl_q.enable & ~ctrl_q.master;

  spi_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .done_i(done), .rx_i(rx_byte), .ctrl_o(ctrl_q), .flag_o(flag),
    .data_wr_o(data_wr), .tx_buf_o(tx_buf));

  spi_rate_div #(.CNT_W(DIV_CNT_W)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(m_busy),
    .rate_i(ctrl_q.rate), .tick_o(tick));

  spi_master_eng #(.DATA_W(DATA_W)) u_master (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(m_en), .cpha_i(ctrl_q.cpha),
    .start_i(data_wr), .tx_i(wdata_i), .tick_i(tick), .miso_i(miso_i),
    .busy_o(m_busy), .lvl_o(m_lvl), .mosi_o(mosi_o), .done_o(m_done),
    .rx_o(m_rx));

  spi_slave_eng #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_slave (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(s_en), .cpol_i(ctrl_q.cpol),
    .cpha_i(ctrl_q.cpha), .sck_i(sck_i), .ss_ni(ss_ni), .mosi_i(mosi_i),
    .tx_i(tx_buf), .miso_o(miso_o), .done_o(s_done), .rx_o(s_rx));

  assign done      = m_done | s_done;
  assign rx_byte   = m_en ? m_rx : s_rx;
  assign irq_o     = flag & ctrl_q.irq_en;
  assign sck_o     = m_lvl ^ ctrl_q.cpol;
  assign sck_oe_o  = m_en;
  assign mosi_oe_o = m_en;
  assign miso_oe_o = s_en & ~ss_ni;
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              spe_i,
  input logic              cpol_i,
  input logic              busy_i,
  input logic              done_i,
  input logic              flag_i,
  input logic              sel_i,
  input logic              we_i,
  input logic [1:0]        addr_i,
  input logic [DATA_W-1:0] rdata_i,
  input logic              sck_i,
  input logic              sck_oe_i,
  input logic              miso_oe_i,
  input logic              irq_i
);
  assert_ctrl_gap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && !we_i && addr_i == 2'd0) |-> !rdata_i[6]);

  assert_sck_idle_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_i |-> sck_i == cpol_i);

  assert_flag_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_i) |-> $past(done_i));

  assert_irq_needs_flag_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> flag_i);

  assert_off_no_drive_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !spe_i |-> (!sck_oe_i && !miso_oe_i));

  assert_idle_quiet_R13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && $past(!busy_i) && $stable(cpol_i)) |-> $stable(sck_i));
endmodule

bind spi_port spi_port_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .spe_i(ctrl_q.enable), .cpol_i(ctrl_q.cpol),
  .busy_i(m_busy), .done_i(done), .flag_i(flag), .sel_i(sel_i), .we_i(we_i),
  .addr_i(addr_i), .rdata_i(rdata_o), .sck_i(sck_o), .sck_oe_i(sck_oe_o),
  .miso_oe_i(miso_oe_o), .irq_i(irq_o));

// File: tb/spi_port_tb.sv
`timescale 1ns/1ps
module spi_port_tb;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sel_i = 1'b0, we_i = 1'b0;
  logic [1:0] addr_i = 2'd0;
  logic [7:0] wdata_i = 8'h00, rdata_o;
  logic       irq_o, sck_i = 1'b0, sck_o, sck_oe_o, ss_ni = 1'b1;
  logic       mosi_i = 1'b0, mosi_o, mosi_oe_o, miso_i = 1'b0, miso_o, miso_oe_o;
  int         checks = 0, fails = 0;
  bit         finished = 1'b0;

  always #4 clk = ~clk;

  spi_port u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .sel_i(sel_i), .we_i(we_i), .addr_i(addr_i),
    .wdata_i(wdata_i), .rdata_o(rdata_o), .irq_o(irq_o), .sck_i(sck_i),
    .sck_o(sck_o), .sck_oe_o(sck_oe_o), .ss_ni(ss_ni), .mosi_i(mosi_i),
    .mosi_o(mosi_o), .mosi_oe_o(mosi_oe_o), .miso_i(miso_i), .miso_o(miso_o),
    .miso_oe_o(miso_oe_o));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    sel_i = 1'b1; we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk);
    sel_i = 1'b0; we_i = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    sel_i = 1'b1; we_i = 1'b0; addr_i = a;
    #1 d = rdata_o;
    @(negedge clk);
    sel_i = 1'b0;
  endtask

  // model peer for master transfers
  task automatic run_master(input logic [7:0] ctrl_v, input logic [7:0] tx, input logic [7:0] stx,
                            output logic [7:0] cap, output int half_meas, output int toggles);
    logic cpha = ctrl_v[2];
    logic prev;
    int   n = 0, t1 = 0, b;
    cap = '0; half_meas = 0; toggles = 0;
    miso_i = cpha ? 1'b0 : stx[7];
    wr(2'd0, ctrl_v);
    wr(2'd2, tx);
    if (!cpha) chk("R5 msb before first edge", mosi_o, tx[7]);
    prev = sck_o;
    while (toggles < 16 && n < 3000) begin
      @(negedge clk);
      n++;
      if (sck_o !== prev) begin
        prev = sck_o;
        toggles++;
        if (toggles == 1) t1 = n;
        if (toggles == 2) half_meas = n - t1;
        b = (toggles - 1) / 2;
        if (toggles % 2 == 1) begin
          if (!cpha) cap[7-b] = mosi_o;
          else miso_i = stx[7-b];
        end else begin
          if (cpha) cap[7-b] = mosi_o;
          else if (b < 7) miso_i = stx[6-b];
        end
      end
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic test_reset_state();
    logic [7:0] d;
    rd(2'd0, d); chk("R1 ctrl reset", d & 8'hFC, 8'h00);
    rd(2'd1, d); chk("R2 status reset", d, 8'h00);
    chk("R11 irq reset", irq_o, 1'b0);
    chk("R12 sck_oe reset", sck_oe_o, 1'b0);
    chk("R12 mosi_oe reset", mosi_oe_o, 1'b0);
    chk("R12 miso_oe reset", miso_oe_o, 1'b0);
  endtask

  task automatic test_ctrl_layout();
    logic [7:0] d;
    wr(2'd0, 8'hFE);
    rd(2'd0, d); chk("R1 ctrl readback bit6 zero", d, 8'hBE);
    wr(2'd0, 8'h02);
    @(negedge clk); rst_ni = 1'b0;
    repeat (2) @(negedge clk); rst_ni = 1'b1;
    rd(2'd0, d); chk("R1 rate kept over reset", d, 8'h02);
  endtask

  task automatic test_master(input logic cpol, input logic cpha, input logic [1:0] rate,
                             input logic [7:0] tx, input logic [7:0] stx);
    logic [7:0] cap, d;
    int hm, tg, exp_half;
    string tag;
    tag = cpha ? "R6" : "R5";
    exp_half = (rate == 0) ? 1 : (rate == 1) ? 2 : (rate == 2) ? 8 : 16;
    run_master({4'b0011, cpol, cpha, rate}, tx, stx, cap, hm, tg);
    chk({tag, " edge count"}, tg, 16);
    chk({tag, " byte on mosi"}, cap, tx);
    chk("R3 half period", hm, exp_half);
    chk("R4 idle level after", sck_o, cpol);
    chk("R12 master enables", {sck_oe_o, mosi_oe_o, miso_oe_o}, 3'b110);
    rd(2'd1, d); chk("R9 flag set", d, 8'h80);
    rd(2'd2, d); chk({"R9 received byte ", tag}, d, stx);
    rd(2'd1, d); chk("R10 flag cleared", d, 8'h00);
  endtask

  task automatic test_flag_irq();
    logic [7:0] cap, d;
    int hm, tg;
    run_master(8'hB1, 8'h3C, 8'hC3, cap, hm, tg);
    chk("R11 irq with enable", irq_o, 1'b1);
    rd(2'd2, d);
    rd(2'd1, d); chk("R10 data access alone keeps flag", d, 8'h80);
    wr(2'd0, 8'h31);
    chk("R11 irq masked", irq_o, 1'b0);
    rd(2'd1, d); chk("R11 flag still set when masked", d, 8'h80);
    rd(2'd2, d);
    rd(2'd1, d); chk("R10 status then data clears", d, 8'h00);
  endtask

  task automatic test_disabled();
    logic [7:0] d;
    logic prev;
    int tg = 0;
    wr(2'd0, 8'h10);
    chk("R12 no drive when off", {sck_oe_o, mosi_oe_o}, 2'b00);
    prev = sck_o;
    wr(2'd2, 8'hA5);
    repeat (200) begin
      @(negedge clk);
      if (sck_o !== prev) tg++;
      prev = sck_o;
    end
    chk("R13 no clock when off", tg, 0);
    rd(2'd1, d); chk("R13 no flag when off", d, 8'h00);
  endtask

  task automatic test_slave(input logic cpol, input logic cpha, input logic [7:0] stx,
                            input logic [7:0] mbyte);
    logic [7:0] cap = '0, d;
    string tag;
    tag = cpha ? "R8" : "R7";
    sck_i = cpol; ss_ni = 1'b1; mosi_i = 1'b0;
    wr(2'd0, {4'b0010, cpol, cpha, 2'b11});
    wr(2'd2, stx);
    repeat (4) @(negedge clk);
    chk("R12 slave no master drive", {sck_oe_o, mosi_oe_o}, 2'b00);
    chk("R12 slave miso off unselected", miso_oe_o, 1'b0);
    if (!cpha) mosi_i = mbyte[7];
    ss_ni = 1'b0;
    repeat (8) @(negedge clk);
    chk("R12 slave miso on selected", miso_oe_o, 1'b1);
    for (int b = 0; b < 8; b++) begin
      if (!cpha) begin
        cap[7-b] = miso_o;
        sck_i = ~cpol;
        repeat (8) @(negedge clk);
        sck_i = cpol;
        if (b < 7) mosi_i = mbyte[6-b];
        repeat (8) @(negedge clk);
      end else begin
        sck_i = ~cpol;
        mosi_i = mbyte[7-b];
        repeat (8) @(negedge clk);
        cap[7-b] = miso_o;
        sck_i = cpol;
        repeat (8) @(negedge clk);
      end
    end
    repeat (4) @(negedge clk);
    chk({tag, " slave byte on miso"}, cap, stx);
    rd(2'd1, d); chk({"R9 slave flag ", tag}, d, 8'h80);
    rd(2'd2, d); chk({tag, " slave received byte"}, d, mbyte);
    ss_ni = 1'b1;
    #1 chk("R12 slave miso released", miso_oe_o, 1'b0);
    rd(2'd1, d); chk("R10 slave flag cleared", d, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    test_reset_state();
    test_ctrl_layout();
    test_master(1'b0, 1'b0, 2'd0, 8'hA5, 8'h5A);
    test_master(1'b1, 1'b0, 2'd1, 8'h81, 8'h7E);
    test_master(1'b0, 1'b1, 2'd2, 8'hC6, 8'h39);
    test_master(1'b1, 1'b1, 2'd3, 8'h1F, 8'hE0);
    test_flag_irq();
    test_disabled();
    test_slave(1'b0, 1'b0, 8'h96, 8'h4B);
    test_slave(1'b1, 1'b0, 8'h0F, 8'hF1);
    test_slave(1'b0, 1'b1, 8'hD2, 8'h2D);
    test_slave(1'b1, 1'b1, 8'h71, 8'h8E);
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule